// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Shared Vector

This block decides which interrupt a small 8-bit core services next. Six primary sources feed it: two external events, two timer overflows, a serial-bus event and a combined "multi-function" request. The combined request is built from three secondary sources (a time base, a real-time clock and a third timer). Each secondary source has its own flag and enable, and the combined request has a further enable of its own. Every primary source has a request flag and an enable bit, and one global enable gates the whole lot.

Requests are latched as flags whenever they occur. The controller looks at them only on a periodic phase strobe. On a strobe, when no service is outstanding and the global enable is set, it picks the highest-priority pending source. It then raises a service handshake toward the core carrying a 3-bit vector index. The handshake is valid/ready: `svc_valid` and `svc_vec` stay put until the core asserts `svc_ready`, and the transfer happens in the cycle where both are high. The core cannot back-pressure anything else, so event inputs are never stalled. On the transfer, hardware clears the global enable and the serviced primary flag. Secondary flags are never cleared by hardware.

Software reaches flags and enables through a small register port. The combined flag is read-only. Register layout:
- Address 0: primary enables in bits 0-4, combined-request enable in bit 5, global enable in bit 7.
- Address 1: primary flags in bits 0-4, combined flag in bit 5.
- Address 2: secondary flags in bits 0-2, secondary enables in bits 4-6.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset every flag, every enable and the global enable read as zero, `svc_valid` is 0 and `svc_vec` is 0.
- R2: Vector indices are fixed: 0 external 0, 1 external 1, 2 timer 0, 3 timer 1, 4 serial bus, 5 multi-function. Among sources whose flag and enable are both set, the lowest index wins. A source whose enable is clear is skipped.
- R3: `svc_valid` rises only in the cycle after a `phase_stb` cycle. A flag that is set before a strobe cycle is serviced on that strobe. An event that arrives between strobes waits for the next one.
- R4: While `svc_valid` is high and `svc_ready` is low, `svc_valid` stays high and `svc_vec` stays unchanged, even if other sources become pending.
- R5: A handshake (`svc_valid` and `svc_ready` both high) drops `svc_valid` and clears the global enable (address 0 bit 7). Only a register write sets that enable again.
- R6: A handshake clears the primary flag selected by `svc_vec` (when it is 0 to 4). Other primary flags are left as they are.
- R7: A handshake on vector 5 leaves all secondary flags unchanged. A secondary flag is cleared only by writing 0 to its bit at address 2.
- R8: The combined flag (address 1 bit 5) is 1 exactly when at least one secondary flag has its own enable set. A secondary flag whose enable is clear raises no request.
- R9: A write to address 1 sets or clears each primary flag to the written bit, whatever the hardware events have done.
- R10: A hardware event on a flag in the same cycle as a software write of 0 to that flag leaves the flag set.
- R11: With the global enable clear, events still set flags, but no strobe raises `svc_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_stb | input | 1 | One-cycle sampling strobe |
| prim_evt | input | 5 | Primary event pulses, bit = vector index |
| sec_evt | input | 3 | Secondary event pulses: 0 time base, 1 real-time clock, 2 timer 2 |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| svc_valid | output | 1 | Service request toward the core |
| svc_vec | output | 3 | Vector index of the request |
| svc_ready | input | 1 | Core accepts the request |

## Verification
Arbitration is tried in several ways:
- A single pending source, for the basic path.
- Several simultaneous flags released one handshake at a time, which shows the fixed order.
- A higher-priority flag with its enable clear, which separates pending from enabled.
- A secondary-only request, which shows the shared vector and that its flags are kept after service.

Timing patterns cover three cases. An event waits through idle cycles without a strobe. A higher-priority event arrives while a request is stalled by the core. An event meets a software clear in the same cycle. Together these tell strobe sampling, the hold rule and the set-over-clear precedence apart.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NPRIM    = 5;
  localparam int NSEC     = 3;
  localparam int NSRC     = NPRIM + 1;
  localparam int VEC_W    = $clog2(NSRC);
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int MF_IDX   = NPRIM;
  localparam int GIE_BIT  = DATA_W - 1;
  localparam int SEN_LSB  = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_ENABLE = 2'd0,
    RA_PFLAG  = 2'd1,
    RA_SEC    = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_prim_bank.sv
module irq_prim_bank
  import irq_pkg::*;
#(
  parameter int N = NPRIM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     evt,
  input  logic             sw_we,
  input  logic [N-1:0]     sw_data,
  input  logic             clr_vld,
  input  logic [VEC_W-1:0] clr_idx,
  output logic [N-1:0]     flag
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic hit;
    assign hit = clr_vld && (clr_idx == VEC_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)        flag[i] <= 1'b0;
      else if (evt[i])   flag[i] <= 1'b1;
      else if (hit)      flag[i] <= 1'b0;
      else if (sw_we)    flag[i] <= sw_data[i];
    end

    // R6: serviced primary flag cleared unless a new event arrives
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !evt[i]) |=> !flag[i]);
    // R10: an event is never lost to a same-cycle clear
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flag[i]);
  end
endmodule

// File: rtl/irq_sec_bank.sv
module irq_sec_bank
  import irq_pkg::*;
#(
  parameter int N = NSEC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         sw_we,
  input  logic [N-1:0] sw_flag,
  input  logic [N-1:0] sw_en,
  output logic [N-1:0] flag,
  output logic [N-1:0] en,
  output logic         mf_req
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)       flag[i] <= 1'b0;
      else if (evt[i])  flag[i] <= 1'b1;
      else if (sw_we)   flag[i] <= sw_flag[i];
    end

    // R7: only a software write of 0 can clear a secondary flag
    a_r7_sw_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[i]) |-> ($past(sw_we) && !$past(sw_flag[i])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      en <= '0;
    else if (sw_we)  en <= sw_en;
  end

  assign mf_req = |(flag & en);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             gie,
  input  logic [N-1:0]     pend,
  input  logic             ready,
  output logic             valid,
  output logic [VEC_W-1:0] vec,
  output logic             take
);
  logic [VEC_W-1:0] win;
  logic             any;

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (pend[k]) begin
        win = VEC_W'(k);
        any = 1'b1;
      end
    end
  end

  assign take = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      vec   <= '0;
    end else if (take) begin
      valid <= 1'b0;
    end else if (!valid && stb && gie && any) begin
      valid <= 1'b1;
      vec   <= win;
    end
  end

  logic [N-1:0] lower_m, sel_m;
  always_comb begin
    for (int k = 0; k < N; k++) begin
      lower_m[k] = (VEC_W'(k) < vec);
      sel_m[k]   = (VEC_W'(k) == vec);
    end
  end

  // R2: chosen source was pending and nothing of higher priority was
  a_r2_priority: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> ((($past(pend) & sel_m) != '0) && (($past(pend) & lower_m) == '0)));
  // R3: request only follows a strobe
  a_r3_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(stb));
  // R4: held until accepted
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(vec)));
  // R11: no request while globally disabled
  a_r11_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(gie));
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_stb,
  input  logic [NPRIM-1:0]  prim_evt,
  input  logic [NSEC-1:0]   sec_evt,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              svc_valid,
  output logic [VEC_W-1:0]  svc_vec,
  input  logic              svc_ready
);
  logic [NPRIM-1:0] prim_flag, prim_en;
  logic [NSEC-1:0]  sec_flag, sec_en;
  logic             mf_req, mf_en, gie, take;
  logic [NSRC-1:0]  pend;
  logic             we_en, we_pf, we_sec;

  assign we_en  = reg_we && (reg_addr == RA_ENABLE);
  assign we_pf  = reg_we && (reg_addr == RA_PFLAG);
  assign we_sec = reg_we && (reg_addr == RA_SEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prim_en <= '0;
      mf_en   <= 1'b0;
    end else if (we_en) begin
      prim_en <= reg_wdata[NPRIM-1:0];
      mf_en   <= reg_wdata[MF_IDX];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      gie <= 1'b0;
    else if (take)   gie <= 1'b0;
    else if (we_en)  gie <= reg_wdata[GIE_BIT];
  end

  irq_prim_bank #(.N(NPRIM)) u_prim (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (prim_evt),
    .sw_we   (we_pf),
    .sw_data (reg_wdata[NPRIM-1:0]),
    .clr_vld (take),
    .clr_idx (svc_vec),
    .flag    (prim_flag)
  );

  irq_sec_bank #(.N(NSEC)) u_sec (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (sec_evt),
    .sw_we   (we_sec),
    .sw_flag (reg_wdata[NSEC-1:0]),
    .sw_en   (reg_wdata[SEN_LSB +: NSEC]),
    .flag    (sec_flag),
    .en      (sec_en),
    .mf_req  (mf_req)
  );

  assign pend = {mf_req && mf_en, prim_flag & prim_en};

  irq_arbiter #(.N(NSRC)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (phase_stb),
    .gie   (gie),
    .pend  (pend),
    .ready (svc_ready),
    .valid (svc_valid),
    .vec   (svc_vec),
    .take  (take)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_ENABLE: begin
        reg_rdata[NPRIM-1:0] = prim_en;
        reg_rdata[MF_IDX]    = mf_en;
        reg_rdata[GIE_BIT]   = gie;
      end
      RA_PFLAG: begin
        reg_rdata[NPRIM-1:0] = prim_flag;
        reg_rdata[MF_IDX]    = mf_req;
      end
      RA_SEC: begin
        reg_rdata[NSEC-1:0]         = sec_flag;
        reg_rdata[SEN_LSB +: NSEC]  = sec_en;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R5: handshake clears the global enable
  a_r5_gie_clear: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie);
  // R8: combined flag follows enabled secondary flags
  a_r8_mf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    mf_req == ((sec_flag & sec_en) != '0));
endmodule

// File: tb/test_irq_ctrl_top.sv
module test_irq_ctrl_top;
  import irq_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_stb = 1'b0;
  logic [4:0] prim_evt = '0;
  logic [2:0] sec_evt = '0;
  logic [1:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic svc_valid;
  logic [2:0] svc_vec;
  logic svc_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_ctrl_top i_irq_ctrl_top (
    .clk(clk), .rst_n(rst_n), .phase_stb(phase_stb), .prim_evt(prim_evt),
    .sec_evt(sec_evt), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .svc_valid(svc_valid),
    .svc_vec(svc_vec), .svc_ready(svc_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_prim(input int idx);
    @(negedge clk); prim_evt[idx] = 1'b1;
    @(negedge clk); prim_evt = '0;
  endtask

  task automatic strobe();
    @(negedge clk); phase_stb = 1'b1;
    @(negedge clk); phase_stb = 1'b0;
    #1;
  endtask

  task automatic ack();
    @(negedge clk); svc_ready = 1'b1;
    @(negedge clk); svc_ready = 1'b0;
    #1;
  endtask

  task automatic clean();
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), d);
      chk(d == 8'h00, "R1 register", d, 0);
    end
    chk(svc_valid == 1'b0, "R1 svc_valid", svc_valid, 0);
    chk(svc_vec == 3'd0, "R1 svc_vec", svc_vec, 0);
  endtask

  task automatic t_polling();
    logic [7:0] d;
    wr(2'd0, 8'h01);
    pulse_prim(0);
    strobe();
    chk(svc_valid == 1'b0, "R11 no request", svc_valid, 0);
    rd(2'd1, d);
    chk(d[0] == 1'b1, "R11 flag latched", d[0], 1);
    clean();
  endtask

  task automatic t_single();
    logic [7:0] d;
    wr(2'd0, 8'h81);
    pulse_prim(0);
    repeat (3) @(negedge clk);
    #1;
    chk(svc_valid == 1'b0, "R3 waits for strobe", svc_valid, 0);
    strobe();
    chk(svc_valid == 1'b1, "R3 serviced on strobe", svc_valid, 1);
    chk(svc_vec == 3'd0, "R2 vector ext0", svc_vec, 0);
    ack();
    chk(svc_valid == 1'b0, "R5 valid dropped", svc_valid, 0);
    rd(2'd0, d);
    chk(d[7] == 1'b0, "R5 global enable cleared", d[7], 0);
    rd(2'd1, d);
    chk(d[0] == 1'b0, "R6 flag cleared", d[0], 0);
    strobe();
    chk(svc_valid == 1'b0, "R5 stays off until write", svc_valid, 0);
    clean();
  endtask

  task automatic t_order();
    logic [7:0] d;
    wr(2'd1, 8'h1A);
    rd(2'd1, d);
    chk(d == 8'h1A, "R9 software set flags", d, 8'h1A);
    wr(2'd0, 8'h9F);
    strobe();
    chk(svc_vec == 3'd1 && svc_valid, "R2 first ext1", svc_vec, 1);
    ack();
    rd(2'd1, d);
    chk(d == 8'h18, "R6 only served flag cleared", d, 8'h18);
    wr(2'd0, 8'h9F);
    strobe();
    chk(svc_vec == 3'd3 && svc_valid, "R2 then timer1", svc_vec, 3);
    ack();
    wr(2'd0, 8'h9F);
    strobe();
    chk(svc_vec == 3'd4 && svc_valid, "R2 then serial", svc_vec, 4);
    ack();
    clean();
  endtask

  task automatic t_enable_skip();
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h84);
    strobe();
    chk(svc_vec == 3'd2 && svc_valid, "R2 disabled ext0 skipped", svc_vec, 2);
    ack();
    clean();
  endtask

  task automatic t_hold();
    wr(2'd0, 8'h9F);
    pulse_prim(3);
    strobe();
    chk(svc_vec == 3'd3 && svc_valid, "R4 initial vector", svc_vec, 3);
    pulse_prim(0);
    strobe();
    strobe();
    chk(svc_valid == 1'b1, "R4 valid held", svc_valid, 1);
    chk(svc_vec == 3'd3, "R4 vector held", svc_vec, 3);
    ack();
    clean();
  endtask

  task automatic t_shared();
    logic [7:0] d;
    wr(2'd2, 8'h10);
    sec_evt[0] = 1'b1;
    @(negedge clk); sec_evt = '0;
    wr(2'd0, 8'hA0);
    strobe();
    chk(svc_vec == 3'd5 && svc_valid, "R8 shared vector", svc_vec, 5);
    ack();
    rd(2'd2, d);
    chk(d == 8'h11, "R7 secondary flag kept", d, 8'h11);
    rd(2'd1, d);
    chk(d[5] == 1'b1, "R8 combined flag still set", d[5], 1);
    wr(2'd2, 8'h10);
    rd(2'd1, d);
    chk(d[5] == 1'b0, "R7 software clear", d[5], 0);
    clean();
  endtask

  task automatic t_sec_masked();
    logic [7:0] d;
    wr(2'd2, 8'h20);
    wr(2'd2, 8'h21);
    wr(2'd0, 8'hA0);
    strobe();
    chk(svc_valid == 1'b0, "R8 masked secondary no request", svc_valid, 0);
    rd(2'd1, d);
    chk(d[5] == 1'b0, "R8 combined flag low", d[5], 0);
    clean();
  endtask

  task automatic t_collide();
    logic [7:0] d;
    wr(2'd1, 8'h04);
    @(negedge clk);
    reg_addr = 2'd1; reg_we = 1'b1; reg_wdata = 8'h00; prim_evt[2] = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; prim_evt = '0;
    rd(2'd1, d);
    chk(d[2] == 1'b1, "R10 event beats clear", d[2], 1);
    wr(2'd1, 8'h00);
    rd(2'd1, d);
    chk(d == 8'h00, "R9 software clear", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_polling();
    t_single();
    t_order();
    t_enable_skip();
    t_hold();
    t_shared();
    t_sec_masked();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule